// File: doc/BRIEF.md
# Power-Up Default Register Loader

After every reset release this block walks a built-in list of default register writes and sends each one as a frame over a shared three-wire serial link. The link has one generated serial clock, one data line, and one active-low load strobe per target. There are three targets: a timing-generator device and two analog front-end devices, A and B. When the walk reaches the terminator entry, the block parks the link idle and raises a done flag. Until then it holds busy high, so the surrounding logic keeps every other serial traffic off the link.

Each list entry names a target, a register address, a data length of 1 to 24 bits and a data value. The loader builds the header from the target type. The timing generator takes a 4-bit address. A front end takes a 3-bit address followed by a test bit that is always low. Both targets then take the data bits, least significant first. The serial clock runs at the system clock divided by `2*HALF_DIV`. With the defaults (`HALF_DIV` = 2) a 40 MHz system clock gives a 10 MHz serial clock.

Top module: `cfg_loader`

## Requirements
- R1: While `rst` is high and at the first edge after it, all strobes are high, `ser_clk` and `ser_data` are low, and `busy` and `done` are low.
- R2: After `rst` falls the walk starts by itself with `busy` high. An `rst` pulse during the walk aborts it, and the whole list is sent again from entry 0.
- R3: A timing-generator frame is sent in this order: a low write bit, then address bits 0..3, then the data bits.
- R4: A front-end frame is sent in this order: a low write bit, then address bits 0..2, then a low test bit, then the data bits. Stored address bit 3 has no effect.
- R5: Each frame carries exactly 5 + length bits. The data is sent least significant bit first.
- R6: `ld_n[0]` selects the timing generator, `ld_n[1]` front end A and `ld_n[2]` front end B. At most one strobe is low at a time, and it stays the same for the whole frame.
- R7: The strobe falls 3*`HALF_DIV` system cycles before the first rising serial-clock edge (one serial period plus the low half of the first bit). It rises 2*`HALF_DIV` cycles after the last falling serial-clock edge.
- R8: `ser_data` changes only while `ser_clk` is low, on the edge where the clock falls. `ser_clk` stays low whenever no strobe is low.
- R9: Between frames all strobes stay high for at least `GAP_SLOTS` (default 2) serial periods.
- R10: The default list is sent in this order, then the terminator raises `done`. Targets are TG (timing generator), FA (front end A) and FB (front end B); the stored address is given.
  - TG, address 1, 16 bits, 0x0C35
  - TG, address 10, 8 bits, 0xA5
  - TG, address 5, 1 bit, 1
  - FA, address 0, 8 bits, 0x81
  - FA, address 3, 10 bits, 0x2F3
  - FB, address 11, 24 bits, 0xC3A55A
  - FB, address 9, 12 bits, 0x5A3
- R11: Once `done` is high it stays high until reset. While it is high, `busy` is low, all strobes are high and `ser_clk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; restarts the walk |
| ser_clk | output | 1 | Generated serial clock, idle low |
| ser_data | output | 1 | Serial data, valid at the rising serial-clock edge |
| ld_n | output | 3 | Active-low load strobes (timing generator, front end A, front end B) |
| busy | output | 1 | High while the default list is being sent |
| done | output | 1 | High once the terminator entry has been reached |

## Verification
A wrong list index or a corrupted shift register shows up at the pins within one frame. Either a decoded frame differs from the expected write, or the frame arrives on the wrong strobe, or it has the wrong bit count. A slip in the slot timer shows up on the first frame as a wrong lead or trail cycle count, or as data moving while the clock is high. A sequencer that stalls or skips the terminator leaves `done` low, or ends with expected frames still queued. A reset in the middle of the walk that fails to restart shows up as a missing or out-of-order first frame.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  localparam int DMAX = 24;
  localparam int LENW = $clog2(DMAX + 1);
  localparam int HDR  = 5;
  localparam int FW   = HDR + DMAX;
  localparam int CNTW = $clog2(FW + 1);
  localparam int NLD  = 3;

  typedef enum logic [1:0] {
    TGT_TG  = 2'd0,
    TGT_FA  = 2'd1,
    TGT_FB  = 2'd2,
    TGT_END = 2'd3
  } tgt_e;

  typedef struct packed {
    tgt_e            tgt;
    logic [3:0]      addr;
    logic [LENW-1:0] len;
    logic [DMAX-1:0] data;
  } entry_t;

  function automatic entry_t mk(tgt_e t, logic [3:0] a, int l, logic [DMAX-1:0] d);
    entry_t e;
    e.tgt  = t;
    e.addr = a;
    e.len  = LENW'(l);
    e.data = d;
    return e;
  endfunction

  // Default write list; anything past the last row is the terminator.
  function automatic entry_t default_entry(int unsigned i);
    case (i)
      0:       return mk(TGT_TG, 4'd1, 16, 24'h000C35);
      1:       return mk(TGT_TG, 4'd10, 8, 24'h0000A5);
      2:       return mk(TGT_TG, 4'd5, 1, 24'h000001);
      3:       return mk(TGT_FA, 4'd0, 8, 24'h000081);
      4:       return mk(TGT_FA, 4'd3, 10, 24'h0002F3);
      5:       return mk(TGT_FB, 4'd11, 24, 24'hC3A55A);
      6:       return mk(TGT_FB, 4'd9, 12, 24'h0005A3);
      default: return mk(TGT_END, 4'd0, 1, 24'h000000);
    endcase
  endfunction
endpackage

// File: rtl/cfg_loader_rom.sv
module cfg_loader_rom
  import cfg_loader_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic [AW-1:0] idx,
  output entry_t        ent_q
);
  entry_t mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_fill
    assign mem[g] = default_entry(g);
  end

  always_ff @(posedge clk) begin
    ent_q <= mem[idx];
  end
endmodule

// File: rtl/cfg_loader_framer.sv
module cfg_loader_framer
  import cfg_loader_pkg::*;
(
  input  entry_t          ent,
  output logic [FW-1:0]   frame,
  output logic [CNTW-1:0] nbits
);
  logic [DMAX-1:0] dmask;

  always_comb begin
    for (int i = 0; i < DMAX; i++) begin
      dmask[i] = (i < int'(ent.len));
    end
  end

  always_comb begin
    frame          = '0;
    frame[0]       = 1'b0;                      // write bit
    frame[3:1]     = ent.addr[2:0];
    frame[4]       = (ent.tgt == TGT_TG) ? ent.addr[3] : 1'b0;  // addr bit 3 or test bit
    frame[FW-1:HDR] = ent.data & dmask;
    nbits          = CNTW'(HDR) + CNTW'(ent.len);
  end
endmodule

// File: rtl/cfg_loader_slot.sv
module cfg_loader_slot #(
  parameter int HALF_DIV = 2,
  localparam int PW = $clog2(2 * HALF_DIV)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic slot_end,
  output logic hi_phase
);
  logic [PW-1:0] ph;

  assign slot_end = run && (ph == PW'(2 * HALF_DIV - 1));
  assign hi_phase = (ph >= PW'(HALF_DIV));

  always_ff @(posedge clk) begin
    if (rst || !run)   ph <= '0;
    else if (slot_end) ph <= '0;
    else               ph <= ph + 1'b1;
  end
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int HALF_DIV  = 2,
  parameter int DEPTH     = 16,
  parameter int GAP_SLOTS = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int GW = $clog2(GAP_SLOTS + 1)
) (
  input  logic           clk,
  input  logic           rst,
  output logic           ser_clk,
  output logic           ser_data,
  output logic [NLD-1:0] ld_n,
  output logic           busy,
  output logic           done
);
  typedef enum logic [2:0] {
    S_FETCH, S_LATCH, S_LEAD, S_BITS, S_TRAIL, S_GAP, S_DONE
  } st_e;

  st_e             st;
  logic [AW-1:0]   idx;
  entry_t          ent_q;
  logic [FW-1:0]   frame, shreg;
  logic [CNTW-1:0] nbits, bits_left;
  tgt_e            tgt_q;
  logic [GW-1:0]   gap_cnt;
  logic            run, slot_end, hi_phase, in_frame;

  assign run      = (st == S_LEAD) || (st == S_BITS) || (st == S_TRAIL) || (st == S_GAP);
  assign in_frame = (st == S_LEAD) || (st == S_BITS) || (st == S_TRAIL);

  cfg_loader_rom #(.DEPTH(DEPTH)) u_rom (.clk(clk), .idx(idx), .ent_q(ent_q));
  cfg_loader_framer u_framer (.ent(ent_q), .frame(frame), .nbits(nbits));
  cfg_loader_slot #(.HALF_DIV(HALF_DIV)) u_slot (
    .clk(clk), .rst(rst), .run(run), .slot_end(slot_end), .hi_phase(hi_phase)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_FETCH;
      idx       <= '0;
      shreg     <= '0;
      bits_left <= '0;
      tgt_q     <= TGT_END;
      gap_cnt   <= '0;
    end else begin
      case (st)
        S_FETCH: st <= S_LATCH;
        S_LATCH: begin
          if (ent_q.tgt == TGT_END) begin
            st <= S_DONE;
          end else begin
            shreg     <= frame;
            bits_left <= nbits;
            tgt_q     <= ent_q.tgt;
            st        <= S_LEAD;
          end
        end
        S_LEAD: if (slot_end) st <= S_BITS;
        S_BITS: begin
          if (slot_end) begin
            shreg     <= shreg >> 1;
            bits_left <= bits_left - 1'b1;
            if (bits_left == CNTW'(1)) st <= S_TRAIL;
          end
        end
        S_TRAIL: begin
          if (slot_end) begin
            gap_cnt <= '0;
            st      <= S_GAP;
          end
        end
        S_GAP: begin
          if (slot_end) begin
            if (gap_cnt == GW'(GAP_SLOTS - 1)) begin
              if (idx == AW'(DEPTH - 1)) begin
                st <= S_DONE;
              end else begin
                idx <= idx + 1'b1;
                st  <= S_FETCH;
              end
            end else begin
              gap_cnt <= gap_cnt + 1'b1;
            end
          end
        end
        default: st <= S_DONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ser_clk  <= 1'b0;
      ser_data <= 1'b0;
      ld_n     <= '1;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      ser_clk  <= (st == S_BITS) && hi_phase;
      ser_data <= (st == S_BITS) && shreg[0];
      for (int t = 0; t < NLD; t++) begin
        ld_n[t] <= !(in_frame && (tgt_q == tgt_e'(2'(t))));
      end
      busy <= (st != S_DONE);
      done <= (st == S_DONE);
    end
  end
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk (
  input logic       clk,
  input logic       rst,
  input logic       ser_clk,
  input logic       ser_data,
  input logic [2:0] ld_n,
  input logic       busy,
  input logic       done
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $countones(~ld_n) <= 1); // R6
  AST_STROBE_HELD: assert property (@(posedge clk) disable iff (rst)
    !(&ld_n) |=> ((&ld_n) || $stable(ld_n))); // R6
  AST_CLK_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    (&ld_n) |-> !ser_clk); // R8
  AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
    ser_clk |=> (!ser_clk || $stable(ser_data))); // R8
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && (&ld_n) && !ser_clk)); // R11
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done |=> done); // R11
endmodule

bind cfg_loader cfg_loader_chk u_chk (
  .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
  .ld_n(ld_n), .busy(busy), .done(done)
);

// File: tb/cfg_loader_bench.sv
module cfg_loader_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;

  typedef struct {
    logic [2:0]  ld;
    int          nb;
    logic [28:0] bits;
    bit          is_tg;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk, ser_data, busy, done;
  logic [2:0] ld_n;

  int checks = 0;
  int fails = 0;
  int frames = 0;
  exp_t exp_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  cfg_loader #(.HALF_DIV(HALF), .DEPTH(16), .GAP_SLOTS(2)) u_cfg_loader (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data),
    .ld_n(ld_n), .busy(busy), .done(done)
  );

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic add(int tgt, logic [3:0] a, int len, logic [23:0] d);
    exp_t e;
    e.ld = 3'b111;
    e.ld[tgt] = 1'b0;
    e.nb = 5 + len;
    e.bits = '0;
    e.bits[1] = a[0];
    e.bits[2] = a[1];
    e.bits[3] = a[2];
    e.bits[4] = (tgt == 0) ? a[3] : 1'b0;
    for (int i = 0; i < len; i++) e.bits[5 + i] = d[i];
    e.is_tg = (tgt == 0);
    exp_q.push_back(e);
  endtask

  task automatic push_defaults();
    add(0, 4'd1, 16, 24'h000C35);
    add(0, 4'd10, 8, 24'h0000A5);
    add(0, 4'd5, 1, 24'h000001);
    add(1, 4'd0, 8, 24'h000081);
    add(1, 4'd3, 10, 24'h0002F3);
    add(2, 4'd11, 24, 24'hC3A55A);
    add(2, 4'd9, 12, 24'h0005A3);
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Monitor: decodes frames at the pins and compares against the queue.
  logic [2:0]  p_ld = 3'b111;
  logic        p_sclk = 1'b0, p_sd = 1'b0;
  bit          inf = 0, rise_seen = 0;
  logic [2:0]  cur_ld = 3'b111;
  int          since_fall = 0, since_sfall = 0, hi_cnt = 1000, bitn = 0;
  logic [28:0] cap = '0;

  always @(negedge clk) begin
    if (rst) begin
      inf = 0;
      hi_cnt = 1000;
    end else begin
      if (p_sclk && ser_clk && (ser_data != p_sd))
        chk(0, "R8", "data moved while clock high", ser_data, p_sd);
      if (!inf) begin
        if (ld_n != 3'b111) begin
          chk(hi_cnt + 1 >= 4 * HALF, "R9", "idle cycles between frames", hi_cnt + 1, 4 * HALF);
          chk($countones(~ld_n) == 1, "R6", "strobes low at frame start", ld_n, 0);
          inf = 1; cur_ld = ld_n; since_fall = 0; since_sfall = 0;
          rise_seen = 0; bitn = 0; cap = '0;
        end else begin
          hi_cnt++;
          if (ser_clk) chk(0, "R8", "clock high with no strobe", 1, 0);
        end
      end else begin
        since_fall++;
        if (ser_clk && !p_sclk) begin
          if (!rise_seen) chk(since_fall == 3 * HALF, "R7", "lead cycles", since_fall, 3 * HALF);
          rise_seen = 1;
          if (bitn < 29) cap[bitn] = ser_data;
          bitn++;
        end
        if (!ser_clk && p_sclk) since_sfall = 0;
        else since_sfall++;
        if (ld_n == 3'b111) begin
          chk(since_sfall == 2 * HALF, "R7", "trail cycles", since_sfall, 2 * HALF);
          inf = 0; hi_cnt = 0; frames++;
          if (exp_q.size() == 0) begin
            chk(0, "R10", "frame beyond the list", bitn, 0);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(cur_ld == e.ld, "R6", "strobe of frame", cur_ld, e.ld);
            chk(bitn == e.nb, "R5", "bit count", bitn, e.nb);
            if (e.is_tg) chk(cap[4:0] == e.bits[4:0], "R3", "header", cap[4:0], e.bits[4:0]);
            else         chk(cap[4:0] == e.bits[4:0], "R4", "header", cap[4:0], e.bits[4:0]);
            chk(cap == e.bits, "R5", "frame bits", cap, e.bits);
          end
        end else if (ld_n != cur_ld) begin
          chk(0, "R6", "strobe changed mid-frame", ld_n, cur_ld);
        end
      end
    end
    p_ld = ld_n; p_sclk = ser_clk; p_sd = ser_data;
  end

  task automatic wait_done();
    int n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(done, "R10", "done reached", done, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R10 watchdog expired: actual 0 expected 1");
    finish_test();
  end

  initial begin
    int base;
    rst = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(ld_n == 3'b111 && !ser_clk && !ser_data && !busy && !done, "R1", "outputs in reset",
        {ld_n, ser_clk, ser_data, busy, done}, 7'b1110000);
    push_defaults();
    @(posedge clk); #1 rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy && !done, "R2", "busy after release", {busy, done}, 2'b10);

    wait_done();
    chk(exp_q.size() == 0, "R10", "frames left unsent", exp_q.size(), 0);
    chk(frames == 7, "R10", "frame count", frames, 7);
    chk(!busy, "R11", "busy with done", busy, 0);
    repeat (60) @(negedge clk);
    chk(done && ld_n == 3'b111 && !ser_clk && !busy, "R11", "quiet after done",
        {done, ld_n, ser_clk, busy}, 6'b111100);

    // Reset after completion, then abort in the middle of the walk.
    @(posedge clk); #1 rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!busy && !done && ld_n == 3'b111, "R1", "outputs in second reset",
        {busy, done, ld_n}, 5'b00111);
    exp_q.delete();
    push_defaults();
    base = frames;
    @(posedge clk); #1 rst = 1'b0;
    while (frames < base + 3) @(negedge clk);
    repeat (20) @(negedge clk);
    @(posedge clk); #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    exp_q.delete();
    push_defaults();
    base = frames;
    @(posedge clk); #1 rst = 1'b0;
    wait_done();
    chk(frames - base == 7, "R2", "frames after restart", frames - base, 7);
    chk(exp_q.size() == 0, "R2", "list fully resent", exp_q.size(), 0);
    finish_test();
  end
endmodule